// File: doc/BRIEF.md
# Peripheral Power and Clock Gating Controller

This block decides, for a single peripheral, whether that peripheral receives supply power and whether it receives a clock. Three per-mode gate bits (run, sleep, deep-sleep) come from elsewhere in the chip. A device-mode code also arrives from outside and is synchronised into the block's clock domain. One software-writable power-hold bit completes the inputs. The gate bit that matches the current mode wins when it is 1. When that gate bit is 0, the power-hold bit chooses between "powered but not clocked" and "fully off".

Each return of power after an unpowered period follows a fixed sequence. The block first waits a settling delay, then applies a peripheral reset with the clock held off, and only then raises the ready flag. Software reads that flag through a two-word register window. A clock-carrying state never loses power in the same edge that stops the clock: a one-cycle drain state stops the clock first.

The state machine has six states. Transitions within the power-up sequence:
- OFF goes to SETTLE when power is requested.
- SETTLE goes to RESET when the settle count expires.
- RESET goes to RUN if the current gate bit is 1, or to IDLE otherwise, when the reset count expires.

Transitions out of the powered states:
- SETTLE and RESET fall back to OFF if the power request disappears.
- IDLE goes to RUN on a clock request, or to OFF when power is no longer requested.
- RUN goes to IDLE when the clock request drops but power is still wanted.
- RUN goes to DRAIN when both the clock and power requests drop.
- DRAIN goes to IDLE if power is requested again, or to OFF otherwise.

Top module: `pgate_ctrl`

## Requirements
- R1: The mode code, after passing through SYNC_STAGES flops, selects the gate bit: 2'b00 selects run, 2'b01 selects sleep, 2'b10 selects deep-sleep.
- R2: When the selected gate bit is 1, the block settles powered and clocked (pwr_en=1, clk_en=1), whatever the power-hold bit holds.
- R3: When the selected gate bit is 0 and the power-hold bit is 0, the block settles with pwr_en=0 and clk_en=0.
- R4: When the selected gate bit is 0 and the power-hold bit is 1, the block settles with pwr_en=1 and clk_en=0.
- R5: On each rise of pwr_en, the following happens with clk_en low throughout: periph_rst stays low for SETTLE_CYCLES cycles, then stays high for RST_CYCLES cycles.
- R6: ready is high only while powered and out of reset. ready is low whenever pwr_en is low. clk_en can rise only while periph_rst is low.
- R7: pwr_en never falls in the same cycle that clk_en is high. Stopping both power and clock spends one cycle with pwr_en=1 and clk_en=0.
- R8: Register word 0 (reg_addr=0) holds the power-hold bit in bit 0; it is read/write. Word 1 (reg_addr=1) shows ready in bit 0 and ignores writes. All other read bits are 0.
- R9: After reset, pwr_en, clk_en, periph_rst and ready are 0, and the power-hold bit reads 0.
- R10: The undefined mode code 2'b11 is treated as run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_in | input | 2 | Device mode code, asynchronous to clk |
| gate_run | input | 1 | Gate bit applied in run mode |
| gate_slp | input | 1 | Gate bit applied in sleep mode |
| gate_dsl | input | 1 | Gate bit applied in deep-sleep mode |
| reg_addr | input | 1 | Register word select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word |
| pwr_en | output | 1 | Peripheral power switch enable |
| clk_en | output | 1 | Registered clock-gate enable |
| periph_rst | output | 1 | Peripheral reset pulse |
| ready | output | 1 | Peripheral usable flag |

## Verification
The assertions check the output-ordering rules on every cycle:
- the clock is never on without power, and power does not fall while the clock is on;
- reset never coexists with the clock;
- ready implies powered and out of reset;
- the sequence starts un-reset and un-ready at each power rise;
- the reserved read bits stay zero.

Some behaviours only the bench scenarios can show, because they depend on counts and on inputs seen through the synchroniser. These are the mode-to-gate selection including the undefined code, the exact settle and reset durations, the hold bit's effect with each gate setting, and the dropping of writes to the status word. The bench's reference model follows these cycle by cycle.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_DEEP  = 2'b10
    } dev_mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SETTLE,
        ST_RESET,
        ST_IDLE,
        ST_RUN,
        ST_DRAIN
    } pg_state_e;
endpackage

// File: rtl/pgate_mode_sync.sv
module pgate_mode_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_in,
    input  logic       gate_run,
    input  logic       gate_slp,
    input  logic       gate_dsl,
    output logic       gate_sel
);
    import pgate_pkg::*;

    logic [1:0] stg [SYNC_STAGES];

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= MODE_RUN;
                    else        stg[0] <= mode_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= MODE_RUN;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    // R1, R10: decode, undefined code falls back to run
    always_comb begin
        case (stg[SYNC_STAGES-1])
            MODE_SLEEP: gate_sel = gate_slp;
            MODE_DEEP:  gate_sel = gate_dsl;
            default:    gate_sel = gate_run;
        endcase
    end
endmodule

// File: rtl/pgate_regs.sv
module pgate_regs (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_addr,
    input  logic                        reg_wr,
    input  logic [pgate_pkg::REG_W-1:0] reg_wdata,
    input  logic                        ready,
    output logic                        hold_bit,
    output logic [pgate_pkg::REG_W-1:0] reg_rdata
);
    import pgate_pkg::*;

    logic wdata_unused;
    assign wdata_unused = ^reg_wdata[REG_W-1:1];

    // R8, R9: word 0 bit 0 writable, resets to 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hold_bit <= 1'b0;
        else if (reg_wr && !reg_addr) hold_bit <= reg_wdata[0];
    end

    always_comb begin
        reg_rdata    = '0;
        reg_rdata[0] = reg_addr ? ready : hold_bit;
    end
endmodule

// File: rtl/pgate_fsm.sv
module pgate_fsm #(
    parameter int SETTLE_CYCLES = 8,
    parameter int RST_CYCLES    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_sel,
    input  logic hold_bit,
    output logic pwr_en,
    output logic clk_en,
    output logic periph_rst,
    output logic ready
);
    import pgate_pkg::*;

    localparam int MAX_CNT = (SETTLE_CYCLES > RST_CYCLES) ? SETTLE_CYCLES : RST_CYCLES;
    localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] RST_LOAD    = CNT_W'(RST_CYCLES - 1);

    pg_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             req_pwr, req_clk;

    assign req_clk = gate_sel;
    assign req_pwr = gate_sel | hold_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = (cnt == '0) ? '0 : cnt - 1'b1;
        unique case (state)
            ST_OFF: begin
                if (req_pwr) begin
                    state_nx = ST_SETTLE;
                    cnt_nx   = SETTLE_LOAD;
                end
            end
            ST_SETTLE: begin
                if (!req_pwr) begin
                    state_nx = ST_OFF;
                end else if (cnt == '0) begin
                    state_nx = ST_RESET;
                    cnt_nx   = RST_LOAD;
                end
            end
            ST_RESET: begin
                if (!req_pwr)        state_nx = ST_OFF;
                else if (cnt == '0)  state_nx = req_clk ? ST_RUN : ST_IDLE;
            end
            ST_IDLE: begin
                if (!req_pwr)      state_nx = ST_OFF;
                else if (req_clk)  state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!req_clk) state_nx = req_pwr ? ST_IDLE : ST_DRAIN;
            end
            ST_DRAIN: begin
                state_nx = req_pwr ? ST_IDLE : ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // registered outputs decoded from next state: glitch-free clock enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_en     <= 1'b0;
            clk_en     <= 1'b0;
            periph_rst <= 1'b0;
            ready      <= 1'b0;
        end else begin
            pwr_en     <= (state_nx != ST_OFF);
            clk_en     <= (state_nx == ST_RUN);
            periph_rst <= (state_nx == ST_RESET);
            ready      <= (state_nx == ST_IDLE) || (state_nx == ST_RUN);
        end
    end
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl #(
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 8,
    parameter int RST_CYCLES    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_in,
    input  logic        gate_run,
    input  logic        gate_slp,
    input  logic        gate_dsl,
    input  logic        reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        pwr_en,
    output logic        clk_en,
    output logic        periph_rst,
    output logic        ready
);
    logic gate_sel;
    logic hold_bit;

    pgate_mode_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_in  (mode_in),
        .gate_run (gate_run),
        .gate_slp (gate_slp),
        .gate_dsl (gate_dsl),
        .gate_sel (gate_sel)
    );

    pgate_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .ready     (ready),
        .hold_bit  (hold_bit),
        .reg_rdata (reg_rdata)
    );

    pgate_fsm #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .RST_CYCLES    (RST_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_sel   (gate_sel),
        .hold_bit   (hold_bit),
        .pwr_en     (pwr_en),
        .clk_en     (clk_en),
        .periph_rst (periph_rst),
        .ready      (ready)
    );
endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        pwr_en,
    input logic        clk_en,
    input logic        periph_rst,
    input logic        ready
);
    p_clk_holds_pwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> pwr_en);

    p_clk_needs_pwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> pwr_en);

    p_rst_no_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst |-> (pwr_en && !clk_en));

    p_ready_powered_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (pwr_en && !periph_rst));

    p_clk_rise_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> (!periph_rst && ready));

    p_pwr_rise_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> (!periph_rst && !ready && !clk_en));

    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:1] == 31'd0);
endmodule

bind pgate_ctrl pgate_ctrl_chk u_chk (.*);

// File: tb/pgate_ctrl_test.sv
module pgate_ctrl_test;
    localparam int SYNC = 2;
    localparam int SETL = 8;
    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_in = 2'b00;
    logic        gate_run = 1'b0, gate_slp = 1'b0, gate_dsl = 1'b0;
    logic        reg_addr = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwr_en, clk_en, periph_rst, ready;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pgate_ctrl #(.SYNC_STAGES(SYNC), .SETTLE_CYCLES(SETL), .RST_CYCLES(RSTC)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model: 0 off, 1 settle, 2 reset, 3 idle, 4 clocked, 5 drain
    int         m_st = 0;
    int         m_cnt = 0;
    bit         m_hold = 0;
    logic [1:0] mq[$];

    initial for (int i = 0; i < SYNC; i++) mq.push_front(2'b00);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_hold = 0;
            mq.delete();
            for (int i = 0; i < SYNC; i++) mq.push_front(2'b00);
        end else begin
            logic [1:0] cur;
            bit gs, rp;
            cur = mq[SYNC-1];
            gs = (cur == 2'b01) ? gate_slp : (cur == 2'b10) ? gate_dsl : gate_run;
            rp = gs | m_hold;
            case (m_st)
                0: if (rp) begin m_st = 1; m_cnt = 0; end
                1: if (!rp) m_st = 0;
                   else begin m_cnt++; if (m_cnt == SETL) begin m_st = 2; m_cnt = 0; end end
                2: if (!rp) m_st = 0;
                   else begin m_cnt++; if (m_cnt == RSTC) m_st = gs ? 4 : 3; end
                3: if (!rp) m_st = 0; else if (gs) m_st = 4;
                4: if (!gs) m_st = rp ? 3 : 5;
                default: m_st = rp ? 3 : 0;
            endcase
            if (reg_wr && !reg_addr) m_hold = reg_wdata[0];
            mq.push_front(mode_in);
            void'(mq.pop_back());
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit rdy;
            rdy = (m_st == 3) || (m_st == 4);
            chk("R3 pwr_en vs model", {31'd0, pwr_en}, {31'd0, m_st != 0});
            chk("R2 clk_en vs model", {31'd0, clk_en}, {31'd0, m_st == 4});
            chk("R5 periph_rst vs model", {31'd0, periph_rst}, {31'd0, m_st == 2});
            chk("R6 ready vs model", {31'd0, ready}, {31'd0, rdy});
            chk("R8 rdata vs model", reg_rdata, {31'd0, reg_addr ? rdy : m_hold});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0; reg_wdata = '0; reg_addr = 1'b0;
    endtask

    task automatic outs(input string tag, input bit p, input bit c, input bit r, input bit y);
        chk({tag, " pwr_en"}, {31'd0, pwr_en}, {31'd0, p});
        chk({tag, " clk_en"}, {31'd0, clk_en}, {31'd0, c});
        chk({tag, " periph_rst"}, {31'd0, periph_rst}, {31'd0, r});
        chk({tag, " ready"}, {31'd0, ready}, {31'd0, y});
    endtask

    localparam int SETTLE_ALL = SYNC + SETL + RSTC + 6;

    initial begin
        int n;
        tick(3);
        // R9: reset state
        outs("R9 reset", 0, 0, 0, 0);
        chk("R9 hold reads 0", reg_rdata, 32'd0);
        rst_n = 1'b1;
        tick(2);
        outs("R9 after reset", 0, 0, 0, 0);

        // R4: hold bit alone keeps power without clock
        wr(1'b0, 32'h0000_0001);
        tick(SETTLE_ALL);
        outs("R4 hold only", 1, 0, 0, 1);
        reg_addr = 1'b1; #1;
        chk("R8 ready readback", reg_rdata, 32'd1);
        reg_addr = 1'b0; #1;
        chk("R8 hold readback", reg_rdata, 32'd1);

        // R2: run gate on, clock runs; hold cleared keeps it
        gate_run = 1'b1;
        tick(SYNC + 3);
        outs("R2 gate on", 1, 1, 0, 1);
        wr(1'b0, 32'h0);
        tick(4);
        outs("R2 hold cleared", 1, 1, 0, 1);

        // R7, R3: both requests drop -> drain then off
        gate_run = 1'b0;
        tick(1);
        n = 0;
        while (pwr_en && n < 10) begin
            if (!clk_en) n++;
            tick(1);
            if (n > 10) break;
        end
        chk("R7 drain cycles with clock off", n, 1);
        tick(4);
        outs("R3 fully off", 0, 0, 0, 0);

        // R1, R5: sleep mode gate powers up with measured sequence
        mode_in = 2'b01; gate_slp = 1'b1;
        n = 0;
        while (!pwr_en && n < 20) begin tick(1); n++; end
        n = 0;
        while (!periph_rst && n < 40) begin
            if (clk_en) n = 100;
            tick(1); n++;
        end
        chk("R5 settle length", n, SETL);
        n = 0;
        while (periph_rst && n < 40) begin tick(1); n++; end
        chk("R5 reset length", n, RSTC);
        outs("R1 sleep gate selected", 1, 1, 0, 1);
        gate_slp = 1'b0; gate_run = 1'b1;
        tick(SYNC + 4);
        outs("R1 run gate ignored in sleep", 0, 0, 0, 0);

        // R10: undefined code acts as run
        mode_in = 2'b11;
        tick(SETTLE_ALL);
        outs("R10 code 11 as run", 1, 1, 0, 1);
        gate_run = 1'b0; gate_slp = 1'b1;
        tick(SYNC + 4);
        outs("R10 sleep gate ignored", 0, 0, 0, 0);
        gate_slp = 1'b0;

        // R1: deep-sleep gate
        mode_in = 2'b10; gate_dsl = 1'b1;
        tick(SETTLE_ALL);
        outs("R1 deep gate selected", 1, 1, 0, 1);
        gate_dsl = 1'b0;
        tick(SYNC + 4);
        outs("R3 deep gate off", 0, 0, 0, 0);

        // R8: write to status word ignored; reserved bits zero
        wr(1'b1, 32'hFFFF_FFFF);
        tick(SETTLE_ALL);
        outs("R8 status write no power", 0, 0, 0, 0);
        reg_addr = 1'b0; #1;
        chk("R8 hold unchanged by word1 write", reg_rdata, 32'd0);
        wr(1'b0, 32'hFFFF_FFFF);
        #1;
        chk("R8 reserved bits zero", reg_rdata, 32'd1);

        // R6: power withdrawn mid-settle, ready stays low, restart
        tick(3);
        wr(1'b0, 32'h0);
        tick(3);
        outs("R6 aborted settle", 0, 0, 0, 0);
        wr(1'b0, 32'h1);
        tick(SETTLE_ALL);
        outs("R6 ready after restart", 1, 0, 0, 1);
        wr(1'b0, 32'h0);
        tick(1);
        outs("R6 ready drops with power", 0, 0, 0, 0);
        tick(5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule